// File: doc/BRIEF.md
# Predicated SIMD Lane Ring with OR Reduction

This block is a ring of byte-wide lanes. Each lane holds eight 8-bit registers plus two predicate bits: an active bit and a spare "else" bit. Every lane executes the same instruction word in the cycle it is presented. A one-cycle compare instruction splits the active lanes into a then-group and an else-group. Instructions that carry the mask flag write back only in active lanes. The ring also provides single-cycle moves from the neighbouring lane, at 8 or 16 bits, wrapping from the last lane to the first. A scalar input can be broadcast to every lane.

On the reduction side, the block ORs one register across all lanes into an 8-bit status register. The OR is done first inside groups of lanes and then across groups, with one register stage between the two levels. A leftmost-select instruction keeps only the lowest-numbered active lane. A put instruction writes the status value into one lane chosen by the scalar input.

Instructions arrive on a valid-qualified port with no back-pressure. The block takes one instruction in every cycle in which `instr_valid` is high. A word presented with `instr_valid` low is ignored entirely.

Top module: `simd_lane_ring`

## Requirements

- R1: After reset, the status output is 0, every lane register is 0, every active bit is 1 and every else bit is 0.
- R2: The instruction word is laid out as {op[16:12], msk[11], rd[10:8], ra[7:5], rb[4:2], fsel[1:0]}. The arithmetic ops write rd in every permitted lane, and they operate on unsigned bytes:
  - op 1: ra+rb, modulo 256.
  - op 2: ra−rb, modulo 256.
  - op 3: ra+rb, saturating at 255.
  - op 4: ra−rb, saturating at 0.
  - op 5: the absolute difference |ra−rb|.
  - op 6: the maximum of ra and rb.
  - op 7: the minimum of ra and rb.
  - op 8: copies ra.
- R3: When msk is 1, every register-writing op leaves its destination unchanged in each lane whose active bit is 0. When msk is 0, the op writes in all lanes.
- R4: The group op (op 15) computes a flag f from ra−rb, with fsel choosing the flag:
  - fsel 0: ra<rb.
  - fsel 1: ra==rb.
  - fsel 2: ra<=rb.
  - fsel 3: ra!=rb.

  In the same cycle it sets active = f & active and else = ~f & active.
- R5: The compare op (op 21) records the borrow and zero outcome of ra−rb without changing the predicate bits. The chained group op (op 16) then subtracts that stored borrow as well, and it ANDs its zero result with the stored zero. This makes a 16-bit compare from a low-byte compare followed by a high-byte chained group op.
- R6: The else op (op 17) copies else into active and clears else. The all op (op 18) sets active to 1 and else to 0 in every lane.
- R7: Op 9 writes, into rd of lane i, register ra of lane i−1. Op 10 takes register ra of lane i+1 instead. Both wrap around the ring.
- R8: Op 11 moves the pair (ra, ra+1) of lane i−1 into (rd, rd+1) of lane i. Op 12 does the same from lane i+1. Register numbers wrap modulo 8.
- R9: Op 13 writes scalar_in into rd of every permitted lane.
- R10: Op 20 loads the status output with the bitwise OR of register ra over all lanes. When msk is 1, inactive lanes contribute 0. The status output changes on the second clock edge after the op is accepted. Back-to-back collect ops give results on consecutive cycles, and the status output holds its value otherwise.
- R11: Op 19 clears the active bit of every lane except the lowest-numbered lane whose active bit is 1. If no lane is active, all lanes stay inactive.
- R12: Op 14 writes the status value into rd of the lane whose index equals scalar_in, regardless of msk. An index at or above the lane count writes nothing.
- R13: While instr_valid is 0, no register, predicate bit or status value changes.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction present this cycle; always accepted |
| instr | input | 17 | Broadcast instruction word |
| scalar_in | input | 8 | Broadcast value or lane index for put |
| status_out | output | 8 | Status scalar loaded by the collect op |

## Verification

The bench builds the block with 16 lanes in groups of 8. Collect results therefore pass through two group ORs and the cross-group stage. The ring wrap between lane 15 and lane 0 can be reached by both the 8-bit and the 16-bit neighbour moves.

Sixteen lanes are enough to give each lane a distinct identity byte, loaded through broadcast, collect and put. With those bytes, every compare flag and every nested then/else split produces a distinct masked-OR value at the status port. A put index of 16 falls just past the last lane, which exercises the out-of-range case of the put op.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int DW      = 8;
  localparam int REGS    = 8;
  localparam int RAW     = $clog2(REGS);
  localparam int OPW     = 5;
  localparam int INSTR_W = OPW + 1 + 3 * RAW + 2;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 5'd0,  OP_ADD  = 5'd1,  OP_SUB   = 5'd2,  OP_ADDS  = 5'd3,
    OP_SUBS  = 5'd4,  OP_ABSD = 5'd5,  OP_MAX   = 5'd6,  OP_MIN   = 5'd7,
    OP_MOV   = 5'd8,  OP_MVL  = 5'd9,  OP_MVR   = 5'd10, OP_MVLP  = 5'd11,
    OP_MVRP  = 5'd12, OP_BCST = 5'd13, OP_PUT   = 5'd14, OP_GRP   = 5'd15,
    OP_GRPC  = 5'd16, OP_ELSE = 5'd17, OP_ALL   = 5'd18, OP_LMOST = 5'd19,
    OP_COLL  = 5'd20, OP_CMP  = 5'd21
  } op_e;

  typedef enum logic [1:0] {
    FL_LT = 2'd0, FL_EQ = 2'd1, FL_LE = 2'd2, FL_NE = 2'd3
  } flag_e;

  typedef struct packed {
    op_e            op;
    logic           msk;
    logic [RAW-1:0] rd;
    logic [RAW-1:0] ra;
    logic [RAW-1:0] rb;
    flag_e          fsel;
  } instr_t;

  function automatic logic [DW-1:0] alu_eval(input op_e op, input logic [DW-1:0] a,
                                             input logic [DW-1:0] b);
    logic [DW:0]   s, d;
    logic [DW-1:0] r;
    s = {1'b0, a} + {1'b0, b};
    d = {1'b0, a} - {1'b0, b};
    case (op)
      OP_ADD:  r = s[DW-1:0];
      OP_SUB:  r = d[DW-1:0];
      OP_ADDS: r = s[DW] ? '1 : s[DW-1:0];
      OP_SUBS: r = d[DW] ? '0 : d[DW-1:0];
      OP_ABSD: r = d[DW] ? (b - a) : d[DW-1:0];
      OP_MAX:  r = (a > b) ? a : b;
      OP_MIN:  r = (a < b) ? a : b;
      default: r = a;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/simd_lane.sv
module simd_lane
  import simd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  instr_t          ins,
  input  logic [DW-1:0]   scalar_in,
  input  logic            put_hit,
  input  logic [DW-1:0]   status_in,
  input  logic [2*DW-1:0] nb_left,
  input  logic [2*DW-1:0] nb_right,
  input  logic            keep,
  output logic [2*DW-1:0] nb_out,
  output logic [DW-1:0]   col_out,
  output logic            mr_out
);
  logic [DW-1:0]  rf [REGS];
  logic           mr, mf, cb, cz;
  logic [RAW-1:0] ra_hi, rd_hi;
  logic [DW-1:0]  a, b;
  logic [DW:0]    diff;
  logic           borrow, zero, flag, wr_ok;
  logic           lo_en, hi_en;
  logic [DW-1:0]  lo_d, hi_d;

  assign ra_hi  = ins.ra + RAW'(1);
  assign rd_hi  = ins.rd + RAW'(1);
  assign a      = rf[ins.ra];
  assign b      = rf[ins.rb];
  assign diff   = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, (ins.op == OP_GRPC) & cb};
  assign borrow = diff[DW];
  assign zero   = (diff[DW-1:0] == '0) & ((ins.op == OP_GRPC) ? cz : 1'b1);
  assign wr_ok  = ~ins.msk | mr;

  always_comb begin
    case (ins.fsel)
      FL_LT:   flag = borrow;
      FL_EQ:   flag = zero;
      FL_LE:   flag = borrow | zero;
      default: flag = ~zero;
    endcase
  end

  always_comb begin
    lo_en = 1'b0;
    hi_en = 1'b0;
    lo_d  = alu_eval(ins.op, a, b);
    hi_d  = '0;
    case (ins.op)
      OP_ADD, OP_SUB, OP_ADDS, OP_SUBS, OP_ABSD, OP_MAX, OP_MIN, OP_MOV:
        lo_en = wr_ok;
      OP_MVL:  begin lo_en = wr_ok; lo_d = nb_left[DW-1:0];  end
      OP_MVR:  begin lo_en = wr_ok; lo_d = nb_right[DW-1:0]; end
      OP_MVLP: begin
        lo_en = wr_ok; hi_en = wr_ok;
        lo_d  = nb_left[DW-1:0]; hi_d = nb_left[2*DW-1:DW];
      end
      OP_MVRP: begin
        lo_en = wr_ok; hi_en = wr_ok;
        lo_d  = nb_right[DW-1:0]; hi_d = nb_right[2*DW-1:DW];
      end
      OP_BCST: begin lo_en = wr_ok;   lo_d = scalar_in; end
      OP_PUT:  begin lo_en = put_hit; lo_d = status_in; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REGS; i++) rf[i] <= '0;
      mr <= 1'b1;
      mf <= 1'b0;
      cb <= 1'b0;
      cz <= 1'b1;
    end else if (en) begin
      if (lo_en) rf[ins.rd] <= lo_d;
      if (hi_en) rf[rd_hi]  <= hi_d;
      case (ins.op)
        OP_GRP, OP_GRPC: begin
          mr <= flag & mr;
          mf <= ~flag & mr;
          cb <= borrow;
          cz <= zero;
        end
        OP_CMP:   begin cb <= borrow; cz <= zero; end
        OP_ELSE:  begin mr <= mf; mf <= 1'b0; end
        OP_ALL:   begin mr <= 1'b1; mf <= 1'b0; end
        OP_LMOST: mr <= mr & keep;
        default: ;
      endcase
    end
  end

  assign nb_out  = {rf[ra_hi], a};
  assign col_out = (ins.msk & ~mr) ? '0 : a;
  assign mr_out  = mr;

  // R3: a masked write in an inactive lane leaves the destination intact
  a_r3_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ins.msk && !mr && (ins.op inside {OP_ADD, OP_SUB, OP_ADDS, OP_SUBS, OP_ABSD,
      OP_MAX, OP_MIN, OP_MOV, OP_MVL, OP_MVR, OP_MVLP, OP_MVRP, OP_BCST}))
    |=> rf[$past(ins.rd)] == $past(rf[ins.rd]));

  // R4: grouping can only narrow the active set
  a_r4_group_narrows: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (ins.op == OP_GRP || ins.op == OP_GRPC)) |=> !(mr && !$past(mr)));

  // R6: then and else bits are never both set
  a_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n) !(mr && mf));
endmodule

// File: rtl/simd_or_tree.sv
module simd_or_tree #(
  parameter int LANES = 16,
  parameter int GROUP = 8,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire,
  input  logic [LANES*DW-1:0] lanes_flat,
  output logic [DW-1:0]       status
);
  localparam int NG = LANES / GROUP;

  logic [DW-1:0] grp_or [NG];
  logic [DW-1:0] grp_q  [NG];
  logic [DW-1:0] glob;
  logic          s1_v;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [DW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int j = 0; j < GROUP; j++) acc = acc | lanes_flat[(g*GROUP+j)*DW +: DW];
    end
    assign grp_or[g] = acc;
  end

  always_comb begin
    glob = '0;
    for (int g = 0; g < NG; g++) glob = glob | grp_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      status <= '0;
      for (int g = 0; g < NG; g++) grp_q[g] <= '0;
    end else begin
      s1_v <= fire;
      if (fire) for (int g = 0; g < NG; g++) grp_q[g] <= grp_or[g];
      if (s1_v) status <= glob;
    end
  end

  // R10: every collect enters the stage register the next cycle
  a_r10_stage_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> s1_v);
  // R10: status only moves when a staged result is pending
  a_r10_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_v |=> $stable(status));
endmodule

// File: rtl/simd_lane_ring.sv
module simd_lane_ring
  import simd_pkg::*;
#(
  parameter int LANES = 16,
  parameter int GROUP = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DW-1:0]      scalar_in,
  output logic [DW-1:0]      status_out
);
  instr_t              ins;
  logic [2*DW-1:0]     nb [LANES];
  logic [LANES*DW-1:0] col_flat;
  logic [LANES-1:0]    mr_vec, seen, put_hit;
  logic                fire;

  assign ins  = instr_t'(instr);
  assign fire = instr_valid && (ins.op == OP_COLL);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int LEFT  = (i + LANES - 1) % LANES;
    localparam int RIGHT = (i + 1) % LANES;

    if (i == 0) begin : g_first
      assign seen[i] = 1'b0;
    end else begin : g_rest
      assign seen[i] = seen[i-1] | mr_vec[i-1];
    end

    assign put_hit[i] = (ins.op == OP_PUT) && (scalar_in == DW'(i));

    simd_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (instr_valid),
      .ins       (ins),
      .scalar_in (scalar_in),
      .put_hit   (put_hit[i]),
      .status_in (status_out),
      .nb_left   (nb[LEFT]),
      .nb_right  (nb[RIGHT]),
      .keep      (~seen[i]),
      .nb_out    (nb[i]),
      .col_out   (col_flat[i*DW +: DW]),
      .mr_out    (mr_vec[i])
    );
  end

  simd_or_tree #(.LANES(LANES), .GROUP(GROUP), .DW(DW)) u_tree (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .lanes_flat (col_flat),
    .status     (status_out)
  );

  // R11: at most one lane stays active after leftmost-select
  a_r11_single_survivor: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && ins.op == OP_LMOST) |=> $onehot0(mr_vec));

  // R11: the survivor was already active
  a_r11_no_new_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && ins.op == OP_LMOST) |=> ((mr_vec & ~$past(mr_vec)) == '0));
endmodule

// File: tb/simd_lane_ring_bench.sv
module simd_lane_ring_bench;
  localparam logic [4:0] O_NOP = 0, O_ADD = 1, O_SUB = 2, O_ADDS = 3, O_SUBS = 4,
    O_ABSD = 5, O_MAX = 6, O_MIN = 7, O_MOV = 8, O_MVL = 9, O_MVR = 10, O_MVLP = 11,
    O_MVRP = 12, O_BCST = 13, O_PUT = 14, O_GRP = 15, O_GRPC = 16, O_ELSE = 17,
    O_ALL = 18, O_LMOST = 19, O_COLL = 20, O_CMP = 21;
  localparam logic [1:0] F_LT = 0, F_EQ = 1, F_LE = 2, F_NE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [16:0] instr = '0;
  logic [7:0]  scalar_in = '0;
  logic [7:0]  status_out;
  int          n_chk = 0, n_err = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  simd_lane_ring u_simd_lane_ring (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .scalar_in(scalar_in), .status_out(status_out)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic m, input logic [2:0] rd,
                       input logic [2:0] ra, input logic [2:0] rb, input logic [1:0] fs,
                       input logic [7:0] sc);
    @(negedge clk);
    instr_valid = 1'b1;
    instr = {op, m, rd, ra, rb, fs};
    scalar_in = sc;
    @(posedge clk);
    #1 instr_valid = 1'b0;
    instr = '0;
  endtask

  task automatic collect_s(input logic m, input logic [2:0] ra, output logic [7:0] v);
    issue(O_COLL, m, 0, ra, 0, 0, 0);
    issue(O_NOP, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    v = status_out;
  endtask

  task automatic read_or(input logic [2:0] ra, output logic [7:0] v);
    collect_s(1'b0, ra, v);
  endtask

  task automatic read_lane(input int k, input logic [2:0] ra, output logic [7:0] v);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_BCST, 0, 5, 0, 0, 0, 8'(k));
    issue(O_GRP, 0, 0, 6, 5, F_EQ, 0);
    collect_s(1'b1, ra, v);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 status after reset", status_out, 8'd0);
    read_or(0, v);
    check("R1 registers zero", v, 8'd0);
    issue(O_BCST, 1, 0, 0, 0, 0, 8'h81);
    read_or(0, v);
    check("R1 lanes active after reset", v, 8'h81);
  endtask

  task automatic t_ids();
    logic [7:0] v;
    for (int k = 0; k < 16; k++) begin
      issue(O_BCST, 0, 7, 0, 0, 0, 8'(k));
      collect_s(1'b0, 7, v);
      issue(O_PUT, 0, 6, 0, 0, 0, 8'(k));
    end
    read_or(6, v);
    check("R9 R12 lane ids OR", v, 8'd15);
    read_lane(9, 6, v);
    check("R12 lane 9 id", v, 8'd9);
  endtask

  task automatic t_alu();
    logic [7:0] v;
    issue(O_BCST, 0, 0, 0, 0, 0, 8'd200);
    issue(O_BCST, 0, 1, 0, 0, 0, 8'd100);
    issue(O_ADD, 0, 2, 0, 1, 0, 0);  read_or(2, v); check("R2 add wrap", v, 8'd44);
    issue(O_SUB, 0, 3, 1, 0, 0, 0);  read_or(3, v); check("R2 sub wrap", v, 8'd156);
    issue(O_ADDS, 0, 2, 0, 1, 0, 0); read_or(2, v); check("R2 sat add", v, 8'd255);
    issue(O_SUBS, 0, 2, 1, 0, 0, 0); read_or(2, v); check("R2 sat sub", v, 8'd0);
    issue(O_ABSD, 0, 2, 1, 0, 0, 0); read_or(2, v); check("R2 absdiff", v, 8'd100);
    issue(O_MAX, 0, 2, 1, 0, 0, 0);  read_or(2, v); check("R2 max", v, 8'd200);
    issue(O_MIN, 0, 2, 0, 1, 0, 0);  read_or(2, v); check("R2 min", v, 8'd100);
    issue(O_MOV, 0, 3, 0, 0, 0, 0);  read_or(3, v); check("R2 mov", v, 8'd200);
    issue(O_ADD, 0, 2, 6, 6, 0, 0);
    read_lane(5, 2, v);  check("R2 per-lane add lane5", v, 8'd10);
    read_lane(15, 2, v); check("R2 per-lane add lane15", v, 8'd30);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_BCST, 0, 5, 0, 0, 0, 8'd3);
    issue(O_GRP, 0, 0, 6, 5, F_EQ, 0);
    issue(O_BCST, 1, 4, 0, 0, 0, 8'h5A);
    read_lane(3, 4, v); check("R3 active lane written", v, 8'h5A);
    read_lane(4, 4, v); check("R3 inactive lane kept", v, 8'h00);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_BCST, 0, 5, 0, 0, 0, 8'd3);
    issue(O_GRP, 0, 0, 6, 5, F_EQ, 0);
    issue(O_BCST, 0, 4, 0, 0, 0, 8'h33);
    read_lane(4, 4, v); check("R3 unmasked writes all", v, 8'h33);
  endtask

  task automatic t_group();
    logic [7:0] v;
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_BCST, 0, 5, 0, 0, 0, 8'd8);
    issue(O_GRP, 0, 0, 6, 5, F_EQ, 0);
    collect_s(1, 6, v); check("R4 EQ then-group", v, 8'd8);
    issue(O_ELSE, 0, 0, 0, 0, 0, 0);
    collect_s(1, 6, v); check("R6 else-group", v, 8'd15);
    issue(O_BCST, 1, 7, 0, 0, 0, 8'h10);
    collect_s(1, 7, v); check("R6 else-group writable", v, 8'h10);
    issue(O_ELSE, 0, 0, 0, 0, 0, 0);
    collect_s(1, 6, v); check("R6 else clears spare", v, 8'd0);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_BCST, 0, 5, 0, 0, 0, 8'd2);
    issue(O_GRP, 0, 0, 6, 5, F_LE, 0);
    collect_s(1, 6, v); check("R4 LE flag", v, 8'd3);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_GRP, 0, 0, 6, 5, F_LT, 0);
    collect_s(1, 6, v); check("R4 LT flag", v, 8'd1);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_BCST, 0, 5, 0, 0, 0, 8'd3);
    issue(O_GRP, 0, 0, 6, 5, F_NE, 0);
    issue(O_ELSE, 0, 0, 0, 0, 0, 0);
    collect_s(1, 6, v); check("R4 NE else is lane3", v, 8'd3);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_BCST, 0, 5, 0, 0, 0, 8'd8);
    issue(O_GRP, 0, 0, 6, 5, F_LT, 0);
    issue(O_BCST, 0, 5, 0, 0, 0, 8'd4);
    issue(O_GRP, 0, 0, 6, 5, F_LT, 0);
    issue(O_ELSE, 0, 0, 0, 0, 0, 0);
    collect_s(1, 6, v); check("R4 nested else lanes 4..7", v, 8'd7);
    issue(O_LMOST, 0, 0, 0, 0, 0, 0);
    collect_s(1, 6, v); check("R11 leftmost of 4..7", v, 8'd4);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_BCST, 0, 5, 0, 0, 0, 8'd6);
    issue(O_GRP, 0, 0, 6, 5, F_LT, 0);
    issue(O_ELSE, 0, 0, 0, 0, 0, 0);
    issue(O_LMOST, 0, 0, 0, 0, 0, 0);
    collect_s(1, 6, v); check("R11 leftmost of 6..15", v, 8'd6);
  endtask

  task automatic t_carry();
    logic [7:0] v;
    issue(O_BCST, 0, 4, 0, 0, 0, 8'd1);
    issue(O_BCST, 0, 3, 0, 0, 0, 8'd1);
    issue(O_BCST, 0, 5, 0, 0, 0, 8'd5);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_CMP, 0, 0, 6, 5, 0, 0);
    issue(O_GRPC, 0, 0, 4, 3, F_LT, 0);
    collect_s(1, 6, v); check("R5 chained LT borrow", v, 8'd7);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_CMP, 0, 0, 6, 5, 0, 0);
    issue(O_GRPC, 0, 0, 4, 3, F_EQ, 0);
    collect_s(1, 6, v); check("R5 chained EQ", v, 8'd5);
    issue(O_BCST, 0, 3, 0, 0, 0, 8'd2);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_CMP, 0, 0, 6, 5, 0, 0);
    issue(O_GRPC, 0, 0, 4, 3, F_LT, 0);
    collect_s(1, 6, v); check("R5 high byte decides", v, 8'd15);
  endtask

  task automatic t_neigh();
    logic [7:0] v;
    issue(O_MVL, 0, 2, 6, 0, 0, 0);
    read_lane(0, 2, v);  check("R7 left wrap lane0", v, 8'd15);
    read_lane(5, 2, v);  check("R7 left lane5", v, 8'd4);
    issue(O_MVR, 0, 2, 6, 0, 0, 0);
    read_lane(15, 2, v); check("R7 right wrap lane15", v, 8'd0);
    read_lane(3, 2, v);  check("R7 right lane3", v, 8'd4);
    issue(O_BCST, 0, 0, 0, 0, 0, 8'd16);
    issue(O_ADD, 0, 7, 6, 0, 0, 0);
    issue(O_MVLP, 0, 2, 6, 0, 0, 0);
    read_lane(0, 2, v);  check("R8 pair left low", v, 8'd15);
    read_lane(0, 3, v);  check("R8 pair left high", v, 8'd31);
    issue(O_MVRP, 0, 2, 6, 0, 0, 0);
    read_lane(15, 2, v); check("R8 pair right low", v, 8'd0);
    read_lane(15, 3, v); check("R8 pair right high", v, 8'd16);
  endtask

  task automatic t_collect();
    logic [7:0] v;
    issue(O_BCST, 0, 1, 0, 0, 0, 8'h21);
    issue(O_COLL, 0, 0, 6, 0, 0, 0);
    check("R10 not yet after one edge", status_out, 8'd16);
    issue(O_COLL, 0, 0, 1, 0, 0, 0);
    @(negedge clk); check("R10 first result", status_out, 8'd15);
    @(negedge clk); check("R10 back-to-back second", status_out, 8'h21);
    issue(O_NOP, 0, 0, 0, 0, 0, 0);
    issue(O_NOP, 0, 0, 0, 0, 0, 0);
    @(negedge clk); check("R10 status holds", status_out, 8'h21);
    instr = {O_COLL, 1'b0, 3'd0, 3'd6, 3'd0, 2'd0};
    instr_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    @(negedge clk); check("R13 invalid collect ignored", status_out, 8'h21);
    instr = {O_BCST, 1'b0, 3'd1, 3'd0, 3'd0, 2'd0};
    scalar_in = 8'h77;
    @(posedge clk);
    #1 instr = '0;
    read_or(1, v); check("R13 invalid write ignored", v, 8'h21);
  endtask

  task automatic t_put();
    logic [7:0] v;
    issue(O_BCST, 0, 7, 0, 0, 0, 8'h44);
    collect_s(0, 7, v);
    issue(O_PUT, 1, 1, 0, 0, 0, 8'd16);
    read_or(1, v); check("R12 out-of-range index", v, 8'h21);
    collect_s(0, 7, v);
    issue(O_ALL, 0, 0, 0, 0, 0, 0);
    issue(O_ELSE, 0, 0, 0, 0, 0, 0);
    issue(O_PUT, 1, 1, 0, 0, 0, 8'd9);
    read_lane(9, 1, v); check("R12 put lane9 ignores mask", v, 8'h44);
    read_lane(8, 1, v); check("R12 lane8 untouched", v, 8'h21);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ids();
    t_alu();
    t_mask();
    t_group();
    t_carry();
    t_neigh();
    t_collect();
    t_put();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule